// File: doc/BRIEF.md
# Paired-Instruction Accumulator Processor

This block is a small accumulator processor core. It executes programs from a word-addressed memory of 40-bit words, where each word holds two 20-bit instructions. Each instruction is an 8-bit operation code followed by a 12-bit operand address.

One memory read brings in a whole word. The left instruction executes first. The right instruction is kept in an internal buffer and executes next without a second fetch. The program counter then steps to the next word.

The core supports three operations: load into the accumulator, sign-magnitude add to the accumulator, and store of the accumulator. An instruction it cannot execute stops the core until reset.

The core drives a single-port synchronous memory. The memory returns read data one cycle after the address is presented. The same address bus carries operand accesses and writes.

Top module: `acc_cpu`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, halt_o, ovf_o and mem_we_o are 0 and mem_addr_o is 0. Execution starts with the word at address 0.
- R2: A word's left instruction sits in bits 39:20, with the opcode in 39:32 and the address in 31:20. The right instruction sits in bits 19:0, with the opcode in 19:12 and the address in 11:0. The left instruction executes before the right one. Each word is read once, and the program counter advances by exactly one after the right half completes.
- R3: Counting the first cycle after reset release as cycle 0, word w is read at address w in cycle 8w+1. The left instruction completes in cycle 8w+4 and the right instruction in cycle 8w+7. Memory read data is expected one cycle after its address.
- R4: Opcode 0x01 loads the addressed word into the accumulator.
- R5: Opcode 0x05 adds the addressed word to the accumulator in sign-magnitude form, with the sign in bit 39 and the magnitude in bits 38:0. Equal signs add the magnitudes and keep the sign. Unequal signs subtract the smaller magnitude from the larger and take the larger operand's sign. Equal magnitudes of opposite sign give +0.
- R6: If a same-sign add carries out of the 39-bit magnitude, the magnitude wraps. ovf_o then rises in the cycle after that add completes and stays high until reset.
- R7: Opcode 0x21 holds mem_we_o high for exactly the completion cycle of the instruction. In that cycle mem_addr_o is the operand address and mem_wdata_o is the accumulator.
- R8: The core halts on any of these conditions: an opcode other than 0x01, 0x05 or 0x21 (including 0x00); an operand address of 1000 or more; a program counter reaching 1000. halt_o rises in cycle 8w+3 for a bad left instruction, 8w+6 for a bad right one, and 8w+1 for an out-of-range counter. Once high, halt_o stays high and no further writes occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 12 | Memory word address for fetches, operand reads and writes |
| mem_wdata_o | output | 40 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 40 | Memory read data, valid one cycle after the address |
| halt_o | output | 1 | Core stopped on an unexecutable instruction or address |
| ovf_o | output | 1 | Sticky add overflow flag |

## Verification
Internal state shows at the ports within one word period (eight cycles), because every word read places the program counter on mem_addr_o.

A bad accumulator value shows up at the next store, as wrong write data. A wrongly captured right half shows up as a wrong operand address, a wrong write, or a halt in the wrong cycle. A program counter that steps on the left half shows up as a fetch of the wrong address, four cycles too early.

The bench replays each program through an instruction-level model and derives the exact cycle of every write, halt and overflow. It compares the ports against that schedule on every clock.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int unsigned WORD_W    = 40;
  localparam int unsigned HALF_W    = WORD_W / 2;
  localparam int unsigned OP_W      = 8;
  localparam int unsigned ADDR_W    = HALF_W - OP_W;
  localparam int unsigned MAG_W     = WORD_W - 1;
  localparam int unsigned MEM_DEPTH = 1000;

  localparam logic [OP_W-1:0] OP_LOAD = 8'h01;
  localparam logic [OP_W-1:0] OP_ADD  = 8'h05;
  localparam logic [OP_W-1:0] OP_STOR = 8'h21;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR,
    ST_FETCH_READ,
    ST_DECODE_LEFT,
    ST_EXEC,
    ST_EXEC_DONE,
    ST_DECODE_RIGHT,
    ST_HALT
  } state_e;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_STOR);
  endfunction
endpackage

// File: rtl/acc_cpu_smadd.sv
module acc_cpu_smadd #(
  parameter int unsigned MAG_W = 39
) (
  input  logic             a_sign_i,
  input  logic [MAG_W-1:0] a_mag_i,
  input  logic             b_sign_i,
  input  logic [MAG_W-1:0] b_mag_i,
  output logic             sum_sign_o,
  output logic [MAG_W-1:0] sum_mag_o,
  output logic             ovf_o
);
  logic [MAG_W:0] mag_sum;

  always_comb begin
    mag_sum    = {1'b0, a_mag_i} + {1'b0, b_mag_i};
    ovf_o      = 1'b0;
    sum_sign_o = 1'b0;
    sum_mag_o  = '0;
    if (a_sign_i == b_sign_i) begin
      sum_sign_o = a_sign_i;
      sum_mag_o  = mag_sum[MAG_W-1:0];
      ovf_o      = mag_sum[MAG_W];
    end else if (a_mag_i > b_mag_i) begin
      sum_sign_o = a_sign_i;
      sum_mag_o  = a_mag_i - b_mag_i;
    end else if (b_mag_i > a_mag_i) begin
      sum_sign_o = b_sign_i;
      sum_mag_o  = b_mag_i - a_mag_i;
    end
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pc_ok_i,
  input  logic   instr_ok_i,
  output state_e state_o,
  output logic   right_o
);
  state_e state_q, state_d;
  logic   right_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH_ADDR:   state_d = pc_ok_i ? ST_FETCH_READ : ST_HALT;
      ST_FETCH_READ:   state_d = ST_DECODE_LEFT;
      ST_DECODE_LEFT:  state_d = instr_ok_i ? ST_EXEC : ST_HALT;
      ST_EXEC:         state_d = ST_EXEC_DONE;
      ST_EXEC_DONE:    state_d = right_q ? ST_FETCH_ADDR : ST_DECODE_RIGHT;
      ST_DECODE_RIGHT: state_d = instr_ok_i ? ST_EXEC : ST_HALT;
      default:         state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH_ADDR;
      right_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DECODE_LEFT)  right_q <= 1'b0;
      if (state_q == ST_DECODE_RIGHT) right_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign right_o = right_q;

  // R2
  right_after_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECODE_RIGHT) |-> !right_q);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              halt_o,
  output logic              ovf_o
);
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(MEM_DEPTH);

  state_e            state;
  logic              right;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [WORD_W-1:0] mbr_q, ac_q;
  logic [OP_W-1:0]   ir_q;
  logic [HALF_W-1:0] ibr_q;
  logic              ovf_q;

  logic [HALF_W-1:0] cand;
  logic [OP_W-1:0]   cand_op;
  logic [ADDR_W-1:0] cand_addr;
  logic              instr_ok, pc_ok;
  logic              sum_sign, sum_ovf;
  logic [MAG_W-1:0]  sum_mag;

  // left half comes straight from the read port, right half from the buffer
  assign cand      = (state == ST_DECODE_LEFT) ? mem_rdata_i[WORD_W-1:HALF_W] : ibr_q;
  assign cand_op   = cand[HALF_W-1:ADDR_W];
  assign cand_addr = cand[ADDR_W-1:0];
  assign instr_ok  = op_known(cand_op) && (cand_addr < ADDR_LIMIT);
  assign pc_ok     = pc_q < ADDR_LIMIT;

  acc_cpu_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_ok_i    (pc_ok),
    .instr_ok_i (instr_ok),
    .state_o    (state),
    .right_o    (right)
  );

  acc_cpu_smadd #(.MAG_W(MAG_W)) u_smadd (
    .a_sign_i   (ac_q[WORD_W-1]),
    .a_mag_i    (ac_q[MAG_W-1:0]),
    .b_sign_i   (mem_rdata_i[WORD_W-1]),
    .b_mag_i    (mem_rdata_i[MAG_W-1:0]),
    .sum_sign_o (sum_sign),
    .sum_mag_o  (sum_mag),
    .ovf_o      (sum_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ac_q  <= '0;
      ir_q  <= '0;
      ibr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH_ADDR: if (pc_ok) mar_q <= pc_q;
        ST_DECODE_LEFT: begin
          mbr_q <= mem_rdata_i;
          ibr_q <= mem_rdata_i[HALF_W-1:0];
          ir_q  <= cand_op;
          mar_q <= cand_addr;
        end
        ST_DECODE_RIGHT: begin
          ir_q  <= cand_op;
          mar_q <= cand_addr;
        end
        ST_EXEC: if (ir_q == OP_STOR) mbr_q <= ac_q;
        ST_EXEC_DONE: begin
          if (ir_q == OP_LOAD) begin
            mbr_q <= mem_rdata_i;
            ac_q  <= mem_rdata_i;
          end else if (ir_q == OP_ADD) begin
            mbr_q <= mem_rdata_i;
            ac_q  <= {sum_sign, sum_mag};
            ovf_q <= ovf_q | sum_ovf;
          end
          if (right) pc_q <= pc_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mbr_q;
  assign mem_we_o    = (state == ST_EXEC_DONE) && (ir_q == OP_STOR);
  assign halt_o      = (state == ST_HALT);
  assign ovf_o       = ovf_q;

  // R8
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  // R8
  halt_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !mem_we_o);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R7
  stor_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == ac_q));
  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q != $past(pc_q)) |-> ((pc_q == $past(pc_q) + 1'b1) && $past(right)));
endmodule

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;
  localparam int MAXC = 8192;
  localparam int DEPTH = 1000;
  localparam int WD_LIMIT = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] mem_addr_o;
  logic [39:0] mem_wdata_o;
  logic        mem_we_o;
  logic [39:0] mem_rdata_i;
  logic        halt_o, ovf_o;

  logic [39:0] mem [0:DEPTH-1];
  int checks = 0, errors = 0, total_cyc = 0;

  bit          exp_we [0:MAXC-1];
  logic [11:0] exp_wa [0:MAXC-1];
  logic [39:0] exp_wd [0:MAXC-1];
  bit          exp_fv [0:MAXC-1];
  logic [11:0] exp_fa [0:MAXC-1];
  int halt_cyc, ovf_cyc;

  acc_cpu dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .mem_rdata_i(mem_rdata_i), .halt_o(halt_o), .ovf_o(ovf_o)
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (mem_we_o && int'(mem_addr_o) < DEPTH) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= (int'(mem_addr_o) < DEPTH) ? mem[mem_addr_o] : 40'h0;
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk_i) begin
    total_cyc++;
    if (total_cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL R3 watchdog expired actual=%0d expected<=%0d", total_cyc, WD_LIMIT);
      report();
      $finish;
    end
  end

  task automatic ck(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] ins(input logic [7:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  function automatic logic [39:0] sm(input bit s, input longint m);
    return {s, 39'(m)};
  endfunction

  // returns {overflow, result}
  function automatic logic [40:0] sm_add(input logic [39:0] a, input logic [39:0] b);
    longint ma = longint'(a[38:0]);
    longint mb = longint'(b[38:0]);
    longint lim = longint'(1) << 39;
    longint s;
    bit o = 0, sg;
    if (a[39] == b[39]) begin
      s = ma + mb; sg = a[39];
      if (s >= lim) begin o = 1; s = s - lim; end
    end else if (ma > mb) begin s = ma - mb; sg = a[39]; end
    else if (mb > ma) begin s = mb - ma; sg = b[39]; end
    else begin s = 0; sg = 0; end
    return {o, sg, 39'(s)};
  endfunction

  task automatic build_model();
    logic [39:0] mm [0:DEPTH-1];
    logic [39:0] ac = '0, word;
    logic [40:0] r;
    logic [19:0] in;
    int pc = 0, w = 0, base, ed;
    for (int i = 0; i < MAXC; i++) begin exp_we[i] = 0; exp_fv[i] = 0; end
    for (int i = 0; i < DEPTH; i++) mm[i] = mem[i];
    halt_cyc = -1; ovf_cyc = -1;
    while (halt_cyc < 0) begin
      base = 8 * w;
      if (pc >= DEPTH) begin halt_cyc = base + 1; break; end
      exp_fv[base+1] = 1; exp_fa[base+1] = 12'(pc);
      word = mm[pc];
      for (int h = 0; h < 2; h++) begin
        in = (h == 0) ? word[39:20] : word[19:0];
        if (!(in[19:12] inside {8'h01, 8'h05, 8'h21}) || int'(in[11:0]) >= DEPTH) begin
          halt_cyc = base + 3 + 3 * h;
          break;
        end
        ed = base + 4 + 3 * h;
        case (in[19:12])
          8'h01: ac = mm[in[11:0]];
          8'h05: begin
            r = sm_add(ac, mm[in[11:0]]);
            ac = r[39:0];
            if (r[40] && ovf_cyc < 0) ovf_cyc = ed;
          end
          default: begin
            mm[in[11:0]] = ac;
            exp_we[ed] = 1; exp_wa[ed] = in[11:0]; exp_wd[ed] = ac;
          end
        endcase
      end
      pc++; w++;
    end
  endtask

  task automatic check_cycle(input int c);
    bit hx, ox;
    hx = (c >= halt_cyc);
    ox = (ovf_cyc >= 0) && (c > ovf_cyc);
    ck(halt_o == hx, "R8 halt_o", 64'(halt_o), 64'(hx));
    ck(ovf_o == ox, "R6 ovf_o", 64'(ovf_o), 64'(ox));
    ck(mem_we_o == exp_we[c], "R3 write timing", 64'(mem_we_o), 64'(exp_we[c]));
    if (exp_we[c]) begin
      ck(mem_addr_o == exp_wa[c], "R7 write address", 64'(mem_addr_o), 64'(exp_wa[c]));
      ck(mem_wdata_o == exp_wd[c], "R7 write data", 64'(mem_wdata_o), 64'(exp_wd[c]));
    end
    if (exp_fv[c]) ck(mem_addr_o == exp_fa[c], "R2 fetch address", 64'(mem_addr_o), 64'(exp_fa[c]));
  endtask

  task automatic start_prog();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic run_prog();
    build_model();
    repeat (2) @(negedge clk_i);
    // R1 reset state
    ck(!halt_o && !ovf_o && !mem_we_o && mem_addr_o == 0, "R1 reset outputs",
       {halt_o, ovf_o, mem_we_o, mem_addr_o}, 64'h0);
    rst_ni = 1'b1;
    for (int c = 0; c <= halt_cyc + 10; c++) begin
      if (c > 0) @(negedge clk_i);
      if (c == 0) ck(!halt_o && !mem_we_o, "R1 first cycle", {halt_o, mem_we_o}, 64'h0);
      check_cycle(c);
    end
  endtask

  initial begin
    // P1: basic load / add / store, opcode zero halts right half
    start_prog();
    mem[0] = {ins(8'h01, 12'd200), ins(8'h05, 12'd201)};
    mem[1] = {ins(8'h21, 12'd202), ins(8'h00, 12'd0)};
    mem[200] = sm(0, 5); mem[201] = sm(0, 7);
    run_prog();
    ck(mem[202] == sm(0, 12), "R5 5+7", mem[202], sm(0, 12));
    ck(halt_cyc == 14, "R8 right-half halt cycle", 64'(halt_cyc), 64'd14);

    // P2: sign mixtures and unknown opcode in left half
    start_prog();
    mem[0] = {ins(8'h01, 12'd300), ins(8'h05, 12'd301)};
    mem[1] = {ins(8'h21, 12'd310), ins(8'h05, 12'd302)};
    mem[2] = {ins(8'h21, 12'd311), ins(8'h05, 12'd303)};
    mem[3] = {ins(8'h21, 12'd312), ins(8'h01, 12'd304)};
    mem[4] = {ins(8'h05, 12'd305), ins(8'h21, 12'd313)};
    mem[5] = {ins(8'hFF, 12'd0), ins(8'h01, 12'd300)};
    mem[300] = sm(0, 10); mem[301] = sm(1, 3); mem[302] = sm(1, 20);
    mem[303] = sm(0, 13); mem[304] = sm(1, 4); mem[305] = sm(1, 6);
    run_prog();
    ck(mem[310] == sm(0, 7),  "R5 +10 + -3",  mem[310], sm(0, 7));
    ck(mem[311] == sm(1, 13), "R5 +7 + -20",  mem[311], sm(1, 13));
    ck(mem[312] == sm(0, 0),  "R5 -13 + +13", mem[312], sm(0, 0));
    ck(mem[313] == sm(1, 10), "R5 -4 + -6",   mem[313], sm(1, 10));
    ck(halt_cyc == 43, "R8 left-half halt cycle", 64'(halt_cyc), 64'd43);

    // P3: magnitude overflow, then out-of-range operand address
    start_prog();
    mem[0] = {ins(8'h01, 12'd400), ins(8'h05, 12'd401)};
    mem[1] = {ins(8'h21, 12'd402), ins(8'h01, 12'd1000)};
    mem[400] = {1'b0, {39{1'b1}}}; mem[401] = sm(0, 2);
    run_prog();
    ck(mem[402] == sm(0, 1), "R6 wrapped sum", mem[402], sm(0, 1));
    ck(ovf_cyc == 7, "R6 overflow cycle", 64'(ovf_cyc), 64'd7);

    // P4: store then reload the same location
    start_prog();
    mem[0] = {ins(8'h01, 12'd500), ins(8'h21, 12'd501)};
    mem[1] = {ins(8'h01, 12'd501), ins(8'h05, 12'd501)};
    mem[2] = {ins(8'h21, 12'd502), ins(8'h05, 12'd501)};
    mem[3] = {ins(8'h21, 12'd503), ins(8'h00, 12'd0)};
    mem[500] = sm(1, 'h123);
    run_prog();
    ck(mem[501] == sm(1, 'h123), "R4 load then store", mem[501], sm(1, 'h123));
    ck(mem[503] == sm(1, 'h369), "R7 stored accumulator", mem[503], sm(1, 'h369));

    // P5: program counter runs off the end of memory
    start_prog();
    for (int i = 0; i < DEPTH; i++) mem[i] = {ins(8'h01, 12'd7), ins(8'h01, 12'd7)};
    run_prog();
    ck(halt_cyc == 8001, "R8 counter limit halt", 64'(halt_cyc), 64'd8001);

    report();
    $finish;
  end
endmodule